// File: doc/BRIEF.md
# Physical Page World-Ownership Checker

This block sits at the very end of the address path and makes the final decision on each physical memory access. Every 4 KB physical page in a small covered range belongs to one of four security worlds. The owner is recorded as a 2-bit code in an internal table. A request carries a physical address, the world of the requester and a read/write flag. One cycle later the block either allows the access or reports a protection fault, together with the page number that faulted. On a fault, no data is returned to the requester.

The table is written through a separate update port. Only a requester from the root world may change an entry. An update from any other world is refused with an error and leaves the table as it was. At reset every page is owned by root, so no other world can reach memory until the table has been programmed. The root world can reach every page in the covered range. An address beyond that range faults for every requester, root included.

Top module: `page_world_guard`

## Requirements
- R1: After reset every table entry holds the root code. A request from a non-root world to any covered page therefore faults, and rsp_valid and upd_done are low until a request or update is made.
- R2: rsp_valid is high in the cycle after a cycle with req_valid high, and low in the cycle after a cycle with req_valid low.
- R3: A request from the root world (code 11) to a page inside the covered range is allowed, whatever that page's entry holds.
- R4: A request from a non-root world is allowed only when the page's entry equals the requester's world code. Otherwise it faults. The world codes are 00 normal, 01 secure, 10 realm and 11 root. Exactly one of rsp_allow and rsp_fault is high whenever rsp_valid is high.
- R5: A request whose page number (req_addr bits [ADDR_W-1:12]) is NUM_PAGES or more faults for every world, root included.
- R6: On a fault, rsp_fault_page equals bits [ADDR_W-1:12] of the faulting address. On an allowed response it is zero.
- R7: An update from the root world to an in-range page replaces that page's entry with upd_code. The new entry governs requests made in the next cycle and later. The cycle after the update, upd_done is high and upd_err is low.
- R8: An update from a non-root world, or an update to a page at or beyond NUM_PAGES, is refused. The cycle after it, upd_done and upd_err are both high, and the table is unchanged.
- R9: When a request and an update fall in the same cycle, the request is judged against the entry as it stood before that update.
- R10: req_write has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Physical address of the access |
| req_world | input | 2 | World code of the requester |
| req_write | input | 1 | Write intent (1) or read (0) |
| upd_valid | input | 1 | Table update present |
| upd_world | input | 2 | World code of the updater |
| upd_page | input | ADDR_W-12 | Page number to update |
| upd_code | input | 2 | New owner code |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 1 | Protection fault, no data returned |
| rsp_fault_page | output | ADDR_W-12 | Page number of the faulting access |
| upd_done | output | 1 | Update result present |
| upd_err | output | 1 | Update refused |

## Verification
A request and a table update can land in the same cycle, and on the same page. The bench provokes this directly: it grants a page to one world and reads that page from the same world in the same cycle, then revokes the page while that world reads it again. It also produces such collisions at random. The bench model judges each request against its copy of the table before it applies that cycle's update. A response that reflects the new entry too early is therefore reported as a failure against R9.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    typedef enum logic [1:0] {
        WORLD_NORMAL = 2'b00,
        WORLD_SECURE = 2'b01,
        WORLD_REALM  = 2'b10,
        WORLD_ROOT   = 2'b11
    } world_e;

    localparam int PAGE_SHIFT = 12;
endpackage

// File: rtl/pwg_locate.sv
// Splits a physical address into its page number and table index and
// flags whether the page lies inside the covered range.
module pwg_locate #(
    parameter int ADDR_W    = 32,
    parameter int NUM_PAGES = 16,
    localparam int PN_W     = ADDR_W - pwg_pkg::PAGE_SHIFT,
    localparam int IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PN_W-1:0]   page_num,
    output logic [IDX_W-1:0]  page_idx,
    output logic              in_range
);
    logic [pwg_pkg::PAGE_SHIFT-1:0] unused_offset;

    always_comb begin
        page_num      = addr[ADDR_W-1:pwg_pkg::PAGE_SHIFT];
        page_idx      = page_num[IDX_W-1:0];
        in_range      = (page_num < PN_W'(NUM_PAGES));
        unused_offset = addr[pwg_pkg::PAGE_SHIFT-1:0];
    end
endmodule

// File: rtl/pwg_table.sv
// Ownership table: one 2-bit world code per covered page, reset to root,
// writable only by the root world. Reads see the entry before any update
// made in the same cycle.
module pwg_table #(
    parameter int NUM_PAGES = 16,
    parameter int PN_W      = 20,
    localparam int IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_world,
    input  logic [PN_W-1:0]  wr_page,
    input  logic [1:0]       wr_code,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_code,
    output logic             wr_done,
    output logic             wr_err
);
    import pwg_pkg::*;

    typedef struct packed {
        logic [NUM_PAGES-1:0][1:0] ent;
        logic                      done;
        logic                      err;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic wr_ok;

    always_comb begin
        tbl_d      = tbl_q;
        wr_ok      = (world_e'(wr_world) == WORLD_ROOT) &&
                     (wr_page < PN_W'(NUM_PAGES));
        tbl_d.done = wr_en;
        tbl_d.err  = wr_en && !wr_ok;
        if (wr_en && wr_ok) begin
            tbl_d.ent[wr_page[IDX_W-1:0]] = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                tbl_q.ent[i] <= WORLD_ROOT;
            end
            tbl_q.done <= 1'b0;
            tbl_q.err  <= 1'b0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_code = tbl_q.ent[rd_idx];
    assign wr_done = tbl_q.done;
    assign wr_err  = tbl_q.err;
endmodule

// File: rtl/pwg_verdict.sv
// Pure decision: root may reach any covered page, other worlds only the
// pages they own, nobody reaches a page outside the range.
module pwg_verdict (
    input  logic       in_range,
    input  logic [1:0] world,
    input  logic [1:0] owner,
    output logic       allow
);
    import pwg_pkg::*;

    always_comb begin
        allow = 1'b0;
        if (in_range) begin
            allow = (world_e'(world) == WORLD_ROOT) || (world == owner);
        end
    end
endmodule

// File: rtl/page_world_guard.sv
module page_world_guard #(
    parameter int ADDR_W    = 32,
    parameter int NUM_PAGES = 16,
    localparam int PN_W     = ADDR_W - pwg_pkg::PAGE_SHIFT,
    localparam int IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_world,
    input  logic              req_write,
    input  logic              upd_valid,
    input  logic [1:0]        upd_world,
    input  logic [PN_W-1:0]   upd_page,
    input  logic [1:0]        upd_code,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_fault,
    output logic [PN_W-1:0]   rsp_fault_page,
    output logic              upd_done,
    output logic              upd_err
);
    typedef struct packed {
        logic            valid;
        logic            allow;
        logic            fault;
        logic [PN_W-1:0] page;
    } rsp_t;

    rsp_t             rsp_d, rsp_q;
    logic [PN_W-1:0]  req_pn;
    logic [IDX_W-1:0] req_idx;
    logic             req_in_range;
    logic [1:0]       owner_code;
    logic             grant;
    logic             unused_intent;

    // Access direction plays no part in the ownership decision.
    assign unused_intent = req_write;

    pwg_locate #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) u_locate (
        .addr     (req_addr),
        .page_num (req_pn),
        .page_idx (req_idx),
        .in_range (req_in_range)
    );

    pwg_table #(.NUM_PAGES(NUM_PAGES), .PN_W(PN_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_world (upd_world),
        .wr_page  (upd_page),
        .wr_code  (upd_code),
        .rd_idx   (req_idx),
        .rd_code  (owner_code),
        .wr_done  (upd_done),
        .wr_err   (upd_err)
    );

    pwg_verdict u_verdict (
        .in_range (req_in_range),
        .world    (req_world),
        .owner    (owner_code),
        .allow    (grant)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.allow = grant;
            rsp_d.fault = !grant;
            rsp_d.page  = grant ? '0 : req_pn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_allow      = rsp_q.allow;
    assign rsp_fault      = rsp_q.fault;
    assign rsp_fault_page = rsp_q.page;
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
    parameter int ADDR_W    = 32,
    parameter int NUM_PAGES = 16,
    localparam int PN_W     = ADDR_W - 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_world,
    input logic              upd_valid,
    input logic [1:0]        upd_world,
    input logic              rsp_valid,
    input logic              rsp_allow,
    input logic              rsp_fault,
    input logic [PN_W-1:0]   rsp_fault_page,
    input logic              upd_done,
    input logic              upd_err
);
    logic [PN_W-1:0] pn;
    logic            in_rng;

    assign pn     = req_addr[ADDR_W-1:12];
    assign in_rng = (pn < PN_W'(NUM_PAGES));

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_root_reaches_covered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_world == 2'b11 && in_rng) |=> rsp_allow);

    assert_single_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_allow != rsp_fault));

    assert_outside_range_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_rng) |=> rsp_fault);

    assert_fault_page_reported_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_fault || rsp_fault_page == $past(pn)));

    assert_update_acknowledged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> upd_done);

    assert_nonroot_update_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_world != 2'b11) |=> (upd_done && upd_err));
endmodule

bind page_world_guard pwg_checker #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) u_pwg_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_world      (req_world),
    .upd_valid      (upd_valid),
    .upd_world      (upd_world),
    .rsp_valid      (rsp_valid),
    .rsp_allow      (rsp_allow),
    .rsp_fault      (rsp_fault),
    .rsp_fault_page (rsp_fault_page),
    .upd_done       (upd_done),
    .upd_err        (upd_err)
);

// File: tb/tb_page_world_guard.sv
module tb_page_world_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int NUM_PAGES  = 16;
    localparam int PN_W       = ADDR_W - 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_world;
    logic              req_write;
    logic              upd_valid;
    logic [1:0]        upd_world;
    logic [PN_W-1:0]   upd_page;
    logic [1:0]        upd_code;
    logic              rsp_valid;
    logic              rsp_allow;
    logic              rsp_fault;
    logic [PN_W-1:0]   rsp_fault_page;
    logic              upd_done;
    logic              upd_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [1:0] model [NUM_PAGES];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_world_guard #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_world(req_world),
        .req_write(req_write),
        .upd_valid(upd_valid), .upd_world(upd_world), .upd_page(upd_page),
        .upd_code(upd_code),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
        .rsp_fault_page(rsp_fault_page), .upd_done(upd_done), .upd_err(upd_err)
    );

    function automatic bit exp_allow(logic [ADDR_W-1:0] a, logic [1:0] w);
        logic [PN_W-1:0] pn = a[ADDR_W-1:12];
        if (pn >= PN_W'(NUM_PAGES)) return 1'b0;
        return (w == 2'b11) || (model[pn[3:0]] == w);
    endfunction

    function automatic bit exp_upd_err(logic [1:0] w, logic [PN_W-1:0] p);
        return (w != 2'b11) || (p >= PN_W'(NUM_PAGES));
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One cycle: drive at a falling edge, expected values from the model as it
    // stood before this cycle's update, sample at the next falling edge.
    task automatic step(bit rv, logic [ADDR_W-1:0] a, logic [1:0] w, bit wr,
                        bit uv, logic [1:0] uw, logic [PN_W-1:0] up, logic [1:0] uc,
                        string tag);
        bit e_allow;
        bit e_err;
        logic [PN_W-1:0] pn;
        req_valid = rv; req_addr = a; req_world = w; req_write = wr;
        upd_valid = uv; upd_world = uw; upd_page = up; upd_code = uc;
        e_allow = exp_allow(a, w);
        e_err   = exp_upd_err(uw, up);
        pn      = a[ADDR_W-1:12];
        @(negedge clk);
        check(rsp_valid == rv, "R2 rsp_valid", rsp_valid, rv);
        if (rv) begin
            check(rsp_allow == e_allow, tag, rsp_allow, e_allow);
            check(rsp_fault == !e_allow, {tag, " R4 fault"}, rsp_fault, !e_allow);
            check(rsp_fault_page == (e_allow ? '0 : pn), "R6 fault page",
                  rsp_fault_page, e_allow ? 0 : pn);
        end
        check(upd_done == uv, "R7 upd_done", upd_done, uv);
        if (uv) begin
            check(upd_err == e_err, e_err ? "R8 refused" : "R7 accepted", upd_err, e_err);
            if (!e_err) model[up[3:0]] = uc;
        end
    endtask

    function automatic string tag_for(logic [ADDR_W-1:0] a, logic [1:0] w, bit wr);
        if (a[ADDR_W-1:12] >= PN_W'(NUM_PAGES)) return "R5 out of range";
        if (w == 2'b11) return "R3 root";
        return wr ? "R10 write intent R4" : "R4 owner match";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_PAGES; i++) model[i] = 2'b11;
        rst_n = 1'b0;
        req_valid = 0; req_addr = '0; req_world = 0; req_write = 0;
        upd_valid = 0; upd_world = 0; upd_page = '0; upd_code = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rsp_valid == 0 && upd_done == 0, "R1 idle after reset", {rsp_valid, upd_done}, 0);

        // R1: fresh table, everything root-owned
        step(1, 32'h0000_3000, 2'b00, 0, 0, 0, '0, 0, "R1 normal faults after reset");
        step(1, 32'h0000_F123, 2'b10, 1, 0, 0, '0, 0, "R1 realm faults after reset");
        step(1, 32'h0000_5000, 2'b11, 0, 0, 0, '0, 0, "R3 root after reset");
        // R5: beyond range, root too
        step(1, 32'h0001_0000, 2'b11, 0, 0, 0, '0, 0, "R5 root beyond range");
        step(1, 32'hFFFF_F000, 2'b00, 1, 0, 0, '0, 0, "R5 top page");
        // R8: refused updates
        step(0, '0, 0, 0, 1, 2'b01, 20'd2, 2'b01, "");
        step(1, 32'h0000_2000, 2'b01, 0, 0, 0, '0, 0, "R8 table unchanged");
        step(0, '0, 0, 0, 1, 2'b11, 20'd16, 2'b00, "");
        // R9: same-cycle grant and read
        step(1, 32'h0000_4000, 2'b10, 0, 1, 2'b11, 20'd4, 2'b10, "R9 old entry still root");
        step(1, 32'h0000_4ABC, 2'b10, 0, 0, 0, '0, 0, "R7 grant visible next cycle");
        // R10: write intent either way
        step(1, 32'h0000_4010, 2'b10, 1, 0, 0, '0, 0, "R10 write allowed");
        // R9: same-cycle revoke
        step(1, 32'h0000_4000, 2'b10, 1, 1, 2'b11, 20'd4, 2'b00, "R9 old entry realm");
        step(1, 32'h0000_4000, 2'b10, 0, 0, 0, '0, 0, "R7 revoke visible");
        step(1, 32'h0000_4000, 2'b00, 0, 0, 0, '0, 0, "R4 normal now owns");

        for (int n = 0; n < 2000; n++) begin
            logic [ADDR_W-1:0] a;
            logic [1:0] w;
            bit wr, rv, uv;
            logic [1:0] uw;
            logic [PN_W-1:0] up;
            a  = $urandom;
            if ($urandom_range(3) != 0) a[ADDR_W-1:12] = PN_W'($urandom_range(NUM_PAGES-1));
            w  = 2'($urandom);
            wr = 1'($urandom);
            rv = ($urandom_range(4) != 0);
            uv = ($urandom_range(9) < 4);
            uw = ($urandom_range(9) < 6) ? 2'b11 : 2'($urandom);
            up = ($urandom_range(7) == 0) ? PN_W'($urandom_range(40))
                                          : (($urandom_range(2) == 0) ? a[ADDR_W-1:12]
                                                                     : PN_W'($urandom_range(NUM_PAGES-1)));
            step(rv, a, w, wr, uv, uw, up, 2'($urandom), tag_for(a, w, wr));
        end

        req_valid = 0; upd_valid = 0;
        @(negedge clk);
        check(rsp_valid == 0 && upd_done == 0, "R2 idle at end", {rsp_valid, upd_done}, 0);
        finish_run();
    end
endmodule